// File: doc/BRIEF.md
# Hex Record Payload Extractor

This block reads the text of a configuration image written as ASCII hex records, one character per handshake. It pulls out only the payload. Each record opens with a colon. Pairs of hex digits are packed into bytes. The first byte of a record gives the payload length. The next three bytes hold a load address and a record kind, and the block reads them and drops them. After that, exactly the counted number of payload bytes go out on a byte stream with a valid/ready handshake.

The checksum, line-end characters and any stray text between records are skipped: the block simply waits for the next colon. The first record of the stream is treated as a header and never produces output. A synchronous reset puts the block back in that state. Typical use is between a character source, such as a serial receiver or a memory reader, and a loader that writes configuration bits.

Top module: `hexrec_parser`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: While the block waits for a record, every accepted character other than a colon (0x3A) is ignored and produces no output.
- R3: All characters up to and including the second colon after reset are discarded, so the first record produces no output.
- R4: Each byte is built from two consecutive hex characters, the first giving bits 7:4 and the second bits 3:0.
- R5: Characters 0x30-0x39 map to values 0-9, 0x41-0x46 map to 10-15, and 0x61-0x66 map to the same values as the matching uppercase letters.
- R6: The first byte after a colon is the payload count. The three bytes that follow it (address high, address low, record kind) are never output.
- R7: After those three bytes, exactly the counted number of bytes are output, in stream order. Checksum and line-end characters that follow are skipped until the next colon.
- R8: A record whose count is 0x00 outputs nothing, and the block goes back to waiting for a colon.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_byte` and `out_valid` keep their values into the next cycle.
- R10: A reset raised in the middle of the stream returns the block to the state of R1 and R3, so the next record after the reset is discarded again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_char | input | 8 | ASCII character from the source |
| in_valid | input | 1 | `in_char` is presented |
| in_ready | output | 1 | Character is taken on this edge if `in_valid` is high |
| out_byte | output | 8 | Extracted payload byte |
| out_valid | output | 1 | `out_byte` holds a byte |
| out_ready | input | 1 | Downstream takes `out_byte` on this edge |

## Verification
The hardest case to reach is a payload byte completing at the same edge as the previous byte is drained, while the source and the sink both insert random idle cycles. Only then is the single output register loaded and emptied at once. The stimulus throttles both sides at random over a long stream of records with counts from zero to six. This makes the complete-and-drain collision, and long stalls, occur many times. Directed records add the zero-count case, mixed-case digits and a reset in the middle of a record.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  localparam logic [7:0] CH_COLON = 8'h3A;

  typedef enum logic [2:0] {
    RS_HUNT,
    RS_COUNT,
    RS_ADDR_HI,
    RS_ADDR_LO,
    RS_KIND,
    RS_DATA
  } rec_state_e;

  // Fold lowercase, remove the '0' offset, close the gap between '9' and 'A'.
  function automatic logic [3:0] char_to_nibble(input logic [7:0] c);
    logic [7:0] up;
    logic [7:0] v;
    up = (c >= 8'h61 && c <= 8'h7A) ? c - 8'h20 : c;
    v  = up - 8'h30;
    if (v > 8'd9) v = v - 8'd7;
    return v[3:0];
  endfunction

endpackage

// File: rtl/hexrec_nibble_pair.sv
module hexrec_nibble_pair
  import hexrec_pkg::*;
#(
  parameter int CHAR_W = 8,
  localparam int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              flush,
  input  logic [CHAR_W-1:0] ch,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);

  logic             half_q;
  logic [NIB_W-1:0] hi_q;
  logic [NIB_W-1:0] nib;

  assign nib       = char_to_nibble(ch[7:0]);
  assign byte_done = take && half_q;
  assign byte_val  = {hi_q, nib};

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      half_q <= 1'b0;
      hi_q   <= '0;
    end else if (take) begin
      half_q <= ~half_q;
      if (!half_q) hi_q <= nib;
    end
  end

endmodule

// File: rtl/hexrec_framer.sv
module hexrec_framer
  import hexrec_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [CHAR_W-1:0]  ch,
  input  logic               byte_done,
  input  logic [COUNT_W-1:0] byte_val,
  output rec_state_e         state,
  output logic               in_record,
  output logic               emit
);

  logic               primed_q;
  logic [COUNT_W-1:0] remain_q;
  logic               is_colon;

  assign is_colon  = (ch[7:0] == CH_COLON);
  assign in_record = (state != RS_HUNT);
  assign emit      = (state == RS_DATA) && byte_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RS_HUNT;
      primed_q <= 1'b0;
      remain_q <= '0;
    end else if (accept) begin
      case (state)
        RS_HUNT: begin
          if (is_colon) begin
            if (primed_q) state <= RS_COUNT;
            primed_q <= 1'b1;
          end
        end
        RS_COUNT: begin
          if (byte_done) begin
            remain_q <= byte_val;
            state    <= RS_ADDR_HI;
          end
        end
        RS_ADDR_HI: if (byte_done) state <= RS_ADDR_LO;
        RS_ADDR_LO: if (byte_done) state <= RS_KIND;
        RS_KIND:    if (byte_done) state <= (remain_q == '0) ? RS_HUNT : RS_DATA;
        RS_DATA: begin
          if (byte_done) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == COUNT_W'(1)) state <= RS_HUNT;
          end
        end
        default: state <= RS_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/hexrec_out_stage.sv
module hexrec_out_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              room
);

  assign room = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_byte  <= load_val;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
  import hexrec_pkg::*;
#(
  parameter int CHAR_W = 8,
  localparam int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  input  logic              out_ready
);

  logic              accept;
  logic              room;
  logic              in_record;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic              emit;
  rec_state_e        rec_state;

  assign in_ready = room;
  assign accept   = in_valid && room;

  hexrec_nibble_pair #(.CHAR_W(CHAR_W)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .take      (accept && in_record),
    .flush     (!in_record),
    .ch        (in_char),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  hexrec_framer #(.CHAR_W(CHAR_W), .COUNT_W(BYTE_W)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .ch        (in_char),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .state     (rec_state),
    .in_record (in_record),
    .emit      (emit)
  );

  hexrec_out_stage #(.BYTE_W(BYTE_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (emit),
    .load_val  (byte_val),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .room      (room)
  );

endmodule

// File: rtl/hexrec_parser_chk.sv
module hexrec_parser_chk
  import hexrec_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [7:0] in_char,
  input logic       in_ready,
  input logic       accept,
  input logic [7:0] out_byte,
  input logic       out_valid,
  input logic       out_ready,
  input rec_state_e rec_state
);

  logic [1:0] colons_q;

  always_ff @(posedge clk) begin
    if (rst) colons_q <= 2'd0;
    else if (accept && in_char == CH_COLON && colons_q != 2'd2) colons_q <= colons_q + 2'd1;
  end

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  p_stall_block_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_first_skip_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (colons_q == 2'd2));

  p_idle_state_r2: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(rec_state));

  p_load_from_input_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(accept));

endmodule

bind hexrec_parser hexrec_parser_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_char   (in_char),
  .in_ready  (in_ready),
  .accept    (accept),
  .out_byte  (out_byte),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .rec_state (rec_state)
);

// File: tb/hexrec_parser_tb.sv
`timescale 1ns/1ps
module hexrec_parser_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_char = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] out_byte;
  logic       out_valid;
  logic       out_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  string cur_req = "R7";
  logic [7:0] chq[$];
  logic [7:0] exq[$];
  logic stall_prev = 1'b0;
  logic [7:0] held = 8'h00;

  always #2.5 clk = ~clk;

  hexrec_parser u_dut (
    .clk(clk), .rst(rst), .in_char(in_char), .in_valid(in_valid), .in_ready(in_ready),
    .out_byte(out_byte), .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nib_char(input logic [3:0] n, input bit lower);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    return (lower ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
  endfunction

  task automatic push_byte(input logic [7:0] b, input bit lower);
    chq.push_back(nib_char(b[7:4], lower));
    chq.push_back(nib_char(b[3:0], lower));
  endtask

  task automatic add_junk(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] j;
      j = 8'h20 + 8'($urandom % 90);
      if (j == 8'h3A) j = 8'h78;
      chq.push_back(j);
    end
  endtask

  task automatic add_record(input int cnt, input bit keep, input bit lower);
    chq.push_back(8'h3A);
    push_byte(8'(cnt), lower);
    push_byte(8'($urandom), lower);
    push_byte(8'($urandom), lower);
    push_byte(8'h00, lower);
    for (int i = 0; i < cnt; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      push_byte(b, lower);
      if (keep) exq.push_back(b);
    end
    push_byte(8'($urandom), lower);
    chq.push_back(8'h0D);
    chq.push_back(8'h0A);
  endtask

  task automatic run_stream();
    while (chq.size() > 0) begin
      @(posedge clk); #1;
      if ($urandom % 4 == 0) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_char  = chq[0];
        @(negedge clk);
        if (in_ready) void'(chq.pop_front());
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (exq.size() == 0 && !out_valid) break;
    end
    chk(exq.size() == 0, cur_req, 8'(exq.size()), 8'h00);
  endtask

  // sink: random back-pressure
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = ($urandom % 3) != 0;
    end
  end

  // monitor: output compare and stall behaviour (R9)
  always @(negedge clk) begin
    if (rst) begin
      stall_prev = 1'b0;
    end else begin
      if (stall_prev) chk(out_valid && out_byte == held, "R9", out_byte, held);
      if (out_valid && !out_ready) begin
        chk(!in_ready, "R9", {7'h0, in_ready}, 8'h00);
        stall_prev = 1'b1;
        held = out_byte;
      end else begin
        stall_prev = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (exq.size() == 0) chk(1'b0, cur_req, out_byte, 8'h00);
        else begin
          logic [7:0] e;
          e = exq.pop_front();
          chk(out_byte == e, cur_req, out_byte, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", {7'h0, out_valid}, 8'h00);
    chk(in_ready == 1'b1, "R1", {7'h0, in_ready}, 8'h01);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", {7'h0, out_valid}, 8'h00);

    // R3: header record never emits
    cur_req = "R3";
    add_junk(5);
    add_record(4, 1'b0, 1'b0);
    add_junk(3);
    run_stream();
    drain();

    // R2: junk while hunting is ignored
    cur_req = "R2";
    add_junk(12);
    add_record(2, 1'b1, 1'b0);
    add_junk(7);
    run_stream();
    drain();

    // R4: high nibble first
    cur_req = "R4";
    chq.push_back(8'h3A);
    push_byte(8'h02, 0); push_byte(8'h00, 0); push_byte(8'h10, 0); push_byte(8'h00, 0);
    push_byte(8'h12, 0); push_byte(8'h21, 0); push_byte(8'hCC, 0);
    exq.push_back(8'h12); exq.push_back(8'h21);
    run_stream();
    drain();

    // R5: mixed case digits
    cur_req = "R5";
    chq.push_back(8'h3A);
    push_byte(8'h03, 0); push_byte(8'h00, 0); push_byte(8'h00, 0); push_byte(8'h00, 0);
    chq.push_back("a"); chq.push_back("F");
    chq.push_back("9"); chq.push_back("c");
    chq.push_back("E"); chq.push_back("0");
    push_byte(8'h55, 1);
    exq.push_back(8'hAF); exq.push_back(8'h9C); exq.push_back(8'hE0);
    run_stream();
    drain();

    // R6: address and kind bytes dropped
    cur_req = "R6";
    chq.push_back(8'h3A);
    push_byte(8'h01, 0); push_byte(8'hFF, 0); push_byte(8'hEE, 1); push_byte(8'h01, 0);
    push_byte(8'h5A, 0); push_byte(8'h00, 0);
    exq.push_back(8'h5A);
    run_stream();
    drain();

    // R8: zero count record, then a normal one
    cur_req = "R8";
    add_record(0, 1'b1, 1'b0);
    add_record(0, 1'b1, 1'b1);
    add_record(1, 1'b1, 1'b0);
    run_stream();
    drain();

    // R7: random record stream under random throttling
    cur_req = "R7";
    for (int r = 0; r < 40; r++) begin
      add_junk($urandom % 3);
      add_record($urandom % 7, 1'b1, 1'($urandom % 2));
    end
    run_stream();
    drain();

    // R10: reset in the middle of a record
    cur_req = "R10";
    chq.push_back(8'h3A); chq.push_back("0"); chq.push_back("3"); chq.push_back("1");
    run_stream();
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", {7'h0, out_valid}, 8'h00);
    chk(in_ready == 1'b1, "R10", {7'h0, in_ready}, 8'h01);
    @(posedge clk); #1;
    rst = 1'b0;
    add_record(3, 1'b0, 1'b0);
    add_record(2, 1'b1, 1'b1);
    run_stream();
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule